// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Controller

This block sits between a simple register slave port and a one-time-programmable fuse macro. Software sets a fuse address (a 4-bit bank and a 3-bit word) in the control register. It then either starts a sense, which reads one 32-bit fuse word into a captured-data register, or starts a burn, which programs a 32-bit value into that word. A burn is accepted only when a 16-bit unlock key is present in the control register. The key is cleared once the burn ends, so every burn needs a fresh unlock.

Each operation is run by a strobe sequencer. It raises the macro strobe for a counted number of cycles and frames the strobe with a setup gap and a hold gap, both sized by a relax count. All counts come from a software-loaded timing register. The sense strobe and the program strobe have separate counts, and each count already includes both relax gaps. A start that is refused, because an operation is running or the key is missing, sets a sticky error flag. Software clears that flag by writing to a clear-alias register.

Top module: `otp_access_ctrl`

## Requirements
- R1: After reset the control register (word offset 0) reads 0x00000000, and the timing register reads its parameter defaults.
- R2: Control bits 6:0 hold the fuse address, formed as bank<<3 | word. That address appears on `fuse_addr` and holds steady for the whole operation.
- R3: Writing a value with bit 0 set to the read-control register (offset 3) while idle starts a sense. Once busy has cleared, the data-capture register (offset 4) holds the fuse word that was sampled on the last strobe cycle.
- R4: Writing the program-data register (offset 5) while idle, with control bits 31:16 equal to 0x3E77, starts a burn. `fuse_prog_en` is high for the whole burn, and `fuse_wdata` carries the written value.
- R5: Control bit 8 (busy) reads 1 while an operation runs and reads 0 after it ends. The strobe is never high while idle.
- R6: The strobe rises relax+1 cycles after the start write. It stays high for count+1-2*(relax+1) cycles and is followed by relax+1 hold cycles. The count is the sense count or the program count, whichever matches the operation.
- R7: When count+1-2*(relax+1) is below 1, the strobe is still high for exactly one cycle.
- R8: A program-data write made while busy, or while the key is absent, performs no burn and sets the error flag (control bit 9).
- R9: A sense start made while busy is ignored: no extra strobe occurs. It also sets the error flag.
- R10: The error flag is sticky. Writing 1 to bit 9 of the clear alias (offset 1) clears it, and writing 0 there leaves it set.
- R11: At the end of a burn, control bits 31:16 return to zero. A second program-data write without a new unlock is then refused.
- R12: The timing register (offset 2) holds the sense count in bits 21:16, the relax count in bits 15:12 and the program count in bits 11:0. Bits 31:22 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe; data appears on the next cycle |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| fuse_strobe | output | 1 | Macro strobe |
| fuse_prog_en | output | 1 | Macro program enable, high for the whole burn |
| fuse_addr | output | 7 | Macro word address |
| fuse_wdata | output | 32 | Macro program data |
| fuse_rdata | input | 32 | Macro sense data |

## Verification
A phase counter that is off by one shows up within one operation. The strobe then rises or falls a cycle early or late against the relax and count values just written, so the bench measures every setup, strobe and hold length at the macro pins. An address or data register loaded at the wrong time changes the fuse word that is burned or sensed; this appears on the very next sense and accumulates in the bench's own copy of the array. A wrong flag state (error not sticky, key not cleared, start not refused while busy) appears on the next control-register read or as an extra strobe pulse, and both are checked straight after each refused request.

// File: rtl/otp_ctrl_pkg.sv
package otp_ctrl_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phase_t;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFS_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] OFS_CTRL_CLR = 3'd1;
  localparam logic [REG_AW-1:0] OFS_TIMING   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_RDCTRL   = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RDDATA   = 3'd4;
  localparam logic [REG_AW-1:0] OFS_PDATA    = 3'd5;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;

  localparam int TRD_W = 6;   // sense strobe count width
  localparam int RLX_W = 4;   // relax count width
  localparam int TPG_W = 12;  // program strobe count width
  localparam int CNT_W = TPG_W + 1;
endpackage

// File: rtl/otp_strobe_seq.sv
module otp_strobe_seq
  import otp_ctrl_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FADDR_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_sense,
  input  logic               start_prog,
  input  logic [FADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0]  wdata_in,
  input  logic [RLX_W-1:0]   relax,
  input  logic [TRD_W-1:0]   cnt_rd,
  input  logic [TPG_W-1:0]   cnt_pg,
  input  logic [DATA_W-1:0]  fuse_rdata,
  output logic               busy,
  output logic               done_prog,
  output logic [DATA_W-1:0]  cap_data,
  output logic               fuse_strobe,
  output logic               fuse_prog_en,
  output logic [FADDR_W-1:0] fuse_addr,
  output logic [DATA_W-1:0]  fuse_wdata
);
  localparam int SUM_W = CNT_W + 1;

  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   sw_m1;
  logic [RLX_W-1:0]   relax_q;
  logic               is_prog;

  // strobe width = count + 1 - 2*(relax+1), never below one cycle
  logic [CNT_W-1:0] cnt_sel;
  logic [SUM_W-1:0] pos, pad;
  logic [CNT_W-1:0] sw_first;

  assign cnt_sel  = start_prog ? CNT_W'(cnt_pg) : CNT_W'(cnt_rd);
  assign pos      = SUM_W'(cnt_sel) + SUM_W'(1);
  assign pad      = SUM_W'({relax, 1'b0}) + SUM_W'(2);
  assign sw_first = (pos > pad) ? CNT_W'(pos - pad) : CNT_W'(1);

  assign busy      = (phase != PH_IDLE);
  assign done_prog = (phase == PH_HOLD) && (cnt == '0) && is_prog;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      cnt          <= '0;
      sw_m1        <= '0;
      relax_q      <= '0;
      is_prog      <= 1'b0;
      cap_data     <= '0;
      fuse_strobe  <= 1'b0;
      fuse_prog_en <= 1'b0;
      fuse_addr    <= '0;
      fuse_wdata   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start_sense || start_prog) begin
            phase        <= PH_SETUP;
            cnt          <= CNT_W'(relax);
            relax_q      <= relax;
            sw_m1        <= sw_first - CNT_W'(1);
            is_prog      <= start_prog;
            fuse_prog_en <= start_prog;
            fuse_addr    <= addr_in;
            if (start_prog) fuse_wdata <= wdata_in;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase       <= PH_STROBE;
            cnt         <= sw_m1;
            fuse_strobe <= 1'b1;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        PH_STROBE: begin
          if (cnt == '0) begin
            phase       <= PH_HOLD;
            cnt         <= CNT_W'(relax_q);
            fuse_strobe <= 1'b0;
            if (!is_prog) cap_data <= fuse_rdata;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          if (cnt == '0) begin
            phase        <= PH_IDLE;
            fuse_prog_en <= 1'b0;
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
      endcase
    end
  end

  // strobe run-length monitor for the width assertion
  logic [CNT_W-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)              run_len <= '0;
    else if (fuse_strobe) run_len <= run_len + CNT_W'(1);
    else                  run_len <= '0;
  end

  AST_STROBE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    fuse_strobe |-> busy);                                             // R5
  AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(fuse_addr));                     // R2
  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(fuse_strobe) |-> (run_len == sw_m1 + CNT_W'(1)));            // R6
  AST_PROG_EN_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> !fuse_prog_en);                        // R4
endmodule

// File: rtl/otp_regs.sv
module otp_regs
  import otp_ctrl_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int FADDR_W = 7,
  parameter logic [TRD_W-1:0] TRD_RST = 6'd10,
  parameter logic [RLX_W-1:0] RLX_RST = 4'd1,
  parameter logic [TPG_W-1:0] TPG_RST = 12'd40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wen,
  input  logic               bus_ren,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic               busy,
  input  logic               done_prog,
  input  logic [BUS_W-1:0]   cap_data,
  output logic               start_sense,
  output logic               start_prog,
  output logic [FADDR_W-1:0] addr_q,
  output logic [BUS_W-1:0]   pdata_q,
  output logic [TRD_W-1:0]   trd_q,
  output logic [RLX_W-1:0]   rlx_q,
  output logic [TPG_W-1:0]   tpg_q
);
  logic [15:0] unlock_q;
  logic        err_q;
  logic        wr_ctrl, wr_clr, wr_tim, wr_rdc, wr_pd;
  logic        key_ok, bad_sense, bad_prog, err_clr;

  assign wr_ctrl = bus_wen && (bus_addr == OFS_CTRL);
  assign wr_clr  = bus_wen && (bus_addr == OFS_CTRL_CLR);
  assign wr_tim  = bus_wen && (bus_addr == OFS_TIMING);
  assign wr_rdc  = bus_wen && (bus_addr == OFS_RDCTRL) && bus_wdata[0];
  assign wr_pd   = bus_wen && (bus_addr == OFS_PDATA);
  assign key_ok  = (unlock_q == UNLOCK_KEY);

  assign start_sense = wr_rdc && !busy;
  assign start_prog  = wr_pd && key_ok && !busy;
  assign bad_sense   = wr_rdc && busy;
  assign bad_prog    = wr_pd && (!key_ok || busy);
  assign err_clr     = wr_clr && bus_wdata[9];

  always_ff @(posedge clk) begin
    if (rst) begin
      unlock_q  <= '0;
      addr_q    <= '0;
      err_q     <= 1'b0;
      pdata_q   <= '0;
      trd_q     <= TRD_RST;
      rlx_q     <= RLX_RST;
      tpg_q     <= TPG_RST;
      bus_rdata <= '0;
    end else begin
      if (done_prog)    unlock_q <= '0;
      else if (wr_ctrl) unlock_q <= bus_wdata[31:16];
      if (wr_ctrl) addr_q <= bus_wdata[FADDR_W-1:0];
      if (bad_sense || bad_prog) err_q <= 1'b1;
      else if (err_clr)          err_q <= 1'b0;
      if (start_prog) pdata_q <= bus_wdata;
      if (wr_tim) begin
        trd_q <= bus_wdata[16 +: TRD_W];
        rlx_q <= bus_wdata[12 +: RLX_W];
        tpg_q <= bus_wdata[0 +: TPG_W];
      end
      if (bus_ren) begin
        case (bus_addr)
          OFS_CTRL, OFS_CTRL_CLR:
            bus_rdata <= {unlock_q, 6'b0, err_q, busy, 1'b0, addr_q};
          OFS_TIMING: bus_rdata <= {10'b0, trd_q, rlx_q, tpg_q};
          OFS_RDDATA: bus_rdata <= cap_data;
          OFS_PDATA:  bus_rdata <= pdata_q;
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);                                    // R10
  AST_KEY_DROPS: assert property (@(posedge clk) disable iff (rst)
    done_prog |=> (unlock_q == 16'h0));                                // R11
  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(start_sense || start_prog));                            // R9
  AST_ONE_START: assert property (@(posedge clk) disable iff (rst)
    $onehot0({start_sense, start_prog}));                              // R3
endmodule

// File: rtl/otp_access_ctrl.sv
module otp_access_ctrl
  import otp_ctrl_pkg::*;
#(
  parameter int BUS_W   = 32,
  parameter int FADDR_W = 7,
  parameter logic [TRD_W-1:0] TRD_RST = 6'd10,
  parameter logic [RLX_W-1:0] RLX_RST = 4'd1,
  parameter logic [TPG_W-1:0] TPG_RST = 12'd40
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wen,
  input  logic               bus_ren,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               fuse_strobe,
  output logic               fuse_prog_en,
  output logic [FADDR_W-1:0] fuse_addr,
  output logic [BUS_W-1:0]   fuse_wdata,
  input  logic [BUS_W-1:0]   fuse_rdata
);
  logic               busy, done_prog, start_sense, start_prog;
  logic [BUS_W-1:0]   cap_data, pdata_q;
  logic [FADDR_W-1:0] addr_q;
  logic [TRD_W-1:0]   trd_q;
  logic [RLX_W-1:0]   rlx_q;
  logic [TPG_W-1:0]   tpg_q;

  otp_regs #(
    .BUS_W(BUS_W), .FADDR_W(FADDR_W),
    .TRD_RST(TRD_RST), .RLX_RST(RLX_RST), .TPG_RST(TPG_RST)
  ) regs_i (
    .clk(clk), .rst(rst),
    .bus_wen(bus_wen), .bus_ren(bus_ren), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .done_prog(done_prog), .cap_data(cap_data),
    .start_sense(start_sense), .start_prog(start_prog),
    .addr_q(addr_q), .pdata_q(pdata_q),
    .trd_q(trd_q), .rlx_q(rlx_q), .tpg_q(tpg_q)
  );

  // program data goes straight from the bus so the burn uses the written value
  otp_strobe_seq #(.DATA_W(BUS_W), .FADDR_W(FADDR_W)) seq_i (
    .clk(clk), .rst(rst),
    .start_sense(start_sense), .start_prog(start_prog),
    .addr_in(addr_q), .wdata_in(bus_wdata),
    .relax(rlx_q), .cnt_rd(trd_q), .cnt_pg(tpg_q),
    .fuse_rdata(fuse_rdata),
    .busy(busy), .done_prog(done_prog), .cap_data(cap_data),
    .fuse_strobe(fuse_strobe), .fuse_prog_en(fuse_prog_en),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata)
  );

  AST_PDATA_MATCH: assert property (@(posedge clk) disable iff (rst)
    (fuse_strobe && fuse_prog_en) |-> (fuse_wdata == pdata_q));        // R4
endmodule

// File: tb/otp_access_ctrl_tb.sv
module otp_access_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        fuse_strobe, fuse_prog_en;
  logic [6:0]  fuse_addr;
  logic [31:0] fuse_wdata, fuse_rdata;

  int checks = 0, fails = 0;
  logic [31:0] fuse_mem [128];
  logic [31:0] exp_mem  [128];
  int stb_cnt;

  localparam logic [2:0] A_CTRL = 3'd0, A_CLR = 3'd1, A_TIM = 3'd2,
                         A_RDC = 3'd3, A_RDD = 3'd4, A_PD = 3'd5;

  always #4 clk = ~clk;

  otp_access_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_ren(bus_ren),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .fuse_strobe(fuse_strobe), .fuse_prog_en(fuse_prog_en),
    .fuse_addr(fuse_addr), .fuse_wdata(fuse_wdata), .fuse_rdata(fuse_rdata)
  );

  // behavioural fuse array: bits only ever go from 0 to 1
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 128; i++) fuse_mem[i] <= 32'h0;
      stb_cnt <= 0;
    end else begin
      if (fuse_strobe && fuse_prog_en)
        fuse_mem[fuse_addr] <= fuse_mem[fuse_addr] | fuse_wdata;
      if (fuse_strobe) stb_cnt <= stb_cnt + 1;
    end
  end
  assign fuse_rdata = (fuse_strobe && !fuse_prog_en) ? fuse_mem[fuse_addr] : 32'h0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int exp_width(int cnt, int rlx);
    int w = cnt + 1 - 2 * (rlx + 1);
    return (w < 1) ? 1 : w;
  endfunction

  task automatic bus_write(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic bus_read(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
  endtask

  task automatic set_timing(int rd, int rlx, int pg);
    bus_write(A_TIM, {10'b0, 6'(rd), 4'(rlx), 12'(pg)});
  endtask

  // full operation with pin-level timing measurement
  task automatic do_op(bit prog, logic [6:0] a, logic [31:0] v, int rlx, int cnt);
    int su = 0, sw = 0, hd = 0;
    logic [31:0] r;
    if (prog) begin
      bus_write(A_CTRL, {16'h3E77, 9'b0, a});
      bus_write(A_PD, v);
    end else begin
      bus_write(A_CTRL, {16'h0, 9'b0, a});
      bus_write(A_RDC, 32'h1);
    end
    while (!fuse_strobe && su < 5000) begin su++; @(negedge clk); end
    chk("R6 setup cycles", su, rlx + 1);
    chk("R2 fuse address", {25'b0, fuse_addr}, {25'b0, a});
    chk("R4 program enable", {31'b0, fuse_prog_en}, {31'b0, prog});
    if (prog) chk("R4 program data", fuse_wdata, v);
    while (fuse_strobe && sw < 5000) begin sw++; @(negedge clk); end
    chk("R6 R7 strobe cycles", sw, exp_width(cnt, rlx));
    if (prog) begin
      while (fuse_prog_en && hd < 5000) begin hd++; @(negedge clk); end
      chk("R6 hold cycles", hd, rlx + 1);
      exp_mem[a] = exp_mem[a] | v;
    end else begin
      repeat (rlx + 1) @(negedge clk);
      bus_read(A_RDD, r);
      chk("R3 sensed word", r, exp_mem[a]);
    end
    bus_read(A_CTRL, r);
    chk("R5 busy clear after op", {31'b0, r[8]}, 32'h0);
    if (prog) chk("R11 key cleared", {16'b0, r[31:16]}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int s0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 128; i++) exp_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    bus_read(A_CTRL, r);
    chk("R1 ctrl reset", r, 32'h0);
    bus_read(A_TIM, r);
    chk("R1 R12 timing reset", r, {10'b0, 6'd10, 4'd1, 12'd40});
    bus_write(A_TIM, 32'hFFFF_FFFF);
    bus_read(A_TIM, r);
    chk("R12 timing field mask", r, 32'h003F_FFFF);

    set_timing(12, 2, 30);
    do_op(1'b0, {4'd3, 3'd5}, 32'h0, 2, 12);
    do_op(1'b1, {4'd3, 3'd5}, 32'h0000_A5A5, 2, 30);
    do_op(1'b1, {4'd3, 3'd5}, 32'h1200_0000, 2, 30);
    do_op(1'b0, {4'd3, 3'd5}, 32'h0, 2, 12);

    // R11: second burn without a new unlock is refused
    s0 = stb_cnt;
    bus_write(A_PD, 32'hFFFF_FFFF);
    repeat (60) @(negedge clk);
    chk("R11 no burn without re-unlock", stb_cnt - s0, 0);
    bus_read(A_CTRL, r);
    chk("R11 R8 error after refused burn", {31'b0, r[9]}, 32'h1);
    bus_write(A_CLR, 32'h0);
    bus_read(A_CTRL, r);
    chk("R10 error sticky on zero clear", {31'b0, r[9]}, 32'h1);
    bus_write(A_CLR, 32'h200);
    bus_read(A_CTRL, r);
    chk("R10 error cleared", {31'b0, r[9]}, 32'h0);

    // R8: wrong key
    bus_write(A_CTRL, {16'h3E76, 9'b0, 7'h11});
    s0 = stb_cnt;
    bus_write(A_PD, 32'h0F0F_0F0F);
    repeat (60) @(negedge clk);
    chk("R8 no strobe on wrong key", stb_cnt - s0, 0);
    bus_read(A_CTRL, r);
    chk("R8 error on wrong key", {31'b0, r[9]}, 32'h1);
    bus_write(A_CLR, 32'h200);
    do_op(1'b0, 7'h11, 32'h0, 2, 12);

    // R9 and R8 while busy: long sense, then extra requests
    set_timing(63, 15, 40);
    bus_write(A_CTRL, {16'h3E77, 9'b0, 7'h11});
    s0 = stb_cnt;
    bus_write(A_RDC, 32'h1);
    bus_read(A_CTRL, r);
    chk("R5 busy during op", {31'b0, r[8]}, 32'h1);
    bus_write(A_RDC, 32'h1);
    bus_write(A_PD, 32'hDEAD_BEEF);
    repeat (120) @(negedge clk);
    chk("R9 single strobe run", stb_cnt - s0, 32);
    bus_read(A_CTRL, r);
    chk("R9 R8 error after busy requests", {31'b0, r[9]}, 32'h1);
    chk("R5 idle after long op", {31'b0, r[8]}, 32'h0);
    bus_write(A_CLR, 32'h200);
    set_timing(12, 2, 30);
    do_op(1'b0, 7'h11, 32'h0, 2, 12);

    // R7: count too small for the relax padding
    set_timing(2, 3, 1);
    do_op(1'b0, {4'd3, 3'd5}, 32'h0, 3, 2);
    do_op(1'b1, 7'h7F, 32'h8000_0001, 3, 1);
    do_op(1'b0, 7'h7F, 32'h0, 3, 2);

    for (int it = 0; it < 40; it++) begin
      int rlx = $urandom % 4;
      int rd  = $urandom % 64;
      int pg  = 8 + $urandom % 64;
      int kind = $urandom % 3;
      logic [6:0] a = {4'($urandom % 16), 3'($urandom % 8)};
      logic [31:0] v = $urandom;
      set_timing(rd, rlx, pg);
      if (kind == 0) do_op(1'b0, a, 32'h0, rlx, rd);
      else if (kind == 1) do_op(1'b1, a, v, rlx, pg);
      else begin
        bus_write(A_CTRL, {16'(v[15:0] ^ 16'h3E77 | 16'h0001) & 16'hFFFE ^ 16'h1000, 9'b0, a});
        s0 = stb_cnt;
        bus_write(A_PD, v);
        repeat (8) @(negedge clk);
        chk("R8 random refused burn", stb_cnt - s0, 0);
        bus_read(A_CTRL, r);
        chk("R8 random error flag", {31'b0, r[9]}, 32'h1);
        bus_write(A_CLR, 32'h200);
        do_op(1'b0, a, 32'h0, rlx, rd);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule